// File: doc/BRIEF.md
# Predicated Subvector Vector Adder

This block is a vector add engine. It treats a run of `subVecLen` consecutive scalars as one element. The vector length counts these groups, and each predicate bit controls one group. A single start command supplies the destination base register, the two source base registers, the group size (1 to 4), the scalar width (8, 16, 32 or 64 bits), the vector length and a 64-bit predicate mask taken from an integer register. An invert flag can flip the sense of every predicate bit.

The engine works on its own model of a 32-entry by 64-bit register file. It handles one whole group per clock. All scalars of that group are read from the register state as it stood before the group, added with wraparound, and written back in the same cycle. A simple host port writes registers while the engine is idle and reads them combinationally at any time. That port is how operands are loaded and results are observed.

Top module: `subvec_pred_adder`

## Requirements
- R1: After reset `busy` and `done` are 0 and every register reads 0.
- R2: While `busy` is 0, `wrEn` writes `wrData` into register `wrAddr`, and that value is visible on `rdData` when `rdAddr` selects it in the following cycle. `rdData` is a combinational read of register `rdAddr`.
- R3: For each enabled group i and each k below `subVecLen`, destination scalar i*subVecLen+k becomes the sum of source scalars i*subVecLen+k. Scalar width is 8<<`elemWidth` bits (codes 0..3 give 8/16/32/64). Scalar j of a vector with base b lives in register (b + j*W/64) mod 32 at bit offset (j*W) mod 64. Source scalars of a group are read before any scalar of that group is written.
- R4: Each sum wraps modulo 2^W. No carry reaches a neighbouring scalar that shares the register.
- R5: Group i uses predicate bit i of `predMask`. A disabled group leaves its destination scalars unchanged.
- R6: With `predInvert` set, group i executes when bit i is 0.
- R7: After a start edge with `vecLen` N>0, `busy` is 1 for exactly N cycles, one group per cycle. `done` is then 1 for the single following cycle. `done` is never 1 while `busy` is 1.
- R8: A start with `vecLen` 0 leaves `busy` at 0, changes no register, and raises `done` for the next cycle.
- R9: While `busy` is 1, both `start` and `wrEn` are ignored.
- R10: A host write and a start in the same idle cycle both take effect, and the operation reads the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (used only when idle) |
| rdBase | input | 5 | Destination base register |
| rs1Base | input | 5 | First source base register |
| rs2Base | input | 5 | Second source base register |
| subVecLen | input | 3 | Scalars per group, 1..4 |
| elemWidth | input | 2 | Scalar width code, W = 8<<code |
| vecLen | input | 7 | Number of groups, 0..64 |
| predMask | input | 64 | Predicate register value, bit i gates group i |
| predInvert | input | 1 | Execute groups whose mask bit is 0 |
| wrEn | input | 1 | Host register write enable |
| wrAddr | input | 5 | Host write register index |
| wrData | input | 64 | Host write data |
| rdAddr | input | 5 | Host read register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 64 | Contents of register rdAddr |

## Verification
Two functions can fall in the same cycle: a host register write and the start of an operation. The bench provokes this by asserting both in one idle cycle, with the write aimed at a source register of group 0. It judges the result by comparing the whole register file against a model that applies the write first. The bench also pulses `start` and `wrEn` in the middle of a running operation. Its per-cycle `busy`/`done` model and a full register comparison then show that both pulses were dropped.

// File: rtl/subvec_pkg.sv
package subvec_pkg;
  localparam int XLEN   = 64;
  localparam int NREG   = 32;
  localparam int MAXVL  = XLEN;
  localparam int MAXSUB = 4;
  localparam int RIW    = $clog2(NREG);
  localparam int VLW    = $clog2(MAXVL + 1);
  localparam int GW     = $clog2(MAXVL);
  localparam int SUBW   = 3;
  localparam int EWW    = 2;
  localparam int LOGX   = $clog2(XLEN);
  localparam int IDXW   = $clog2(MAXVL * MAXSUB);
  localparam int BPW    = IDXW + LOGX;

  typedef struct packed {
    logic [RIW-1:0]  rdBase;
    logic [RIW-1:0]  rs1Base;
    logic [RIW-1:0]  rs2Base;
    logic [SUBW-1:0] subLen;
    logic [EWW-1:0]  elemW;
  } opCfg_t;

  typedef struct packed {
    logic          doGroup;
    logic          groupEn;
    logic          hostWr;
    logic [GW-1:0] groupIdx;
  } dpStrobe_t;
endpackage

// File: rtl/subvec_ctrl.sv
module subvec_ctrl
  import subvec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  opCfg_t           cfgIn,
  input  logic [VLW-1:0]   vecLen,
  input  logic [XLEN-1:0]  predMask,
  input  logic             predInvert,
  input  logic             wrEn,
  output opCfg_t           cfgQ,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             done
);
  logic [VLW-1:0]  vlQ;
  logic [XLEN-1:0] maskQ;
  logic            invQ;
  logic [GW-1:0]   grpQ;
  logic            lastGroup;

  assign lastGroup = ({1'b0, grpQ} == (vlQ - VLW'(1)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      grpQ  <= '0;
      vlQ   <= '0;
      maskQ <= '0;
      invQ  <= 1'b0;
      cfgQ  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        cfgQ  <= cfgIn;
        vlQ   <= vecLen;
        maskQ <= predMask;
        invQ  <= predInvert;
        grpQ  <= '0;
        if (vecLen != '0) busy <= 1'b1;
        else              done <= 1'b1;
      end else if (busy) begin
        if (lastGroup) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          grpQ <= grpQ + GW'(1);
        end
      end
    end
  end

  always_comb begin
    strb.doGroup  = busy;
    strb.groupEn  = busy && (maskQ[grpQ] ^ invQ);
    strb.hostWr   = wrEn && !busy;
    strb.groupIdx = grpQ;
  end

  // R7: completion follows the last group, never overlaps it
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r7_no_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
  // R8: empty vector completes at once without going busy
  a_r8_empty_vector: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && vecLen == '0) |=> (done && !busy));
  // R9: a start during an operation leaves its configuration alone
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(cfgQ));
endmodule

// File: rtl/subvec_datapath.sv
module subvec_datapath
  import subvec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  opCfg_t           cfg,
  input  dpStrobe_t        strb,
  input  logic [RIW-1:0]   wrAddr,
  input  logic [XLEN-1:0]  wrData,
  input  logic [RIW-1:0]   rdAddr,
  output logic [XLEN-1:0]  rdData
);
  logic [XLEN-1:0] regFile  [NREG];
  logic [XLEN-1:0] nextRegs [NREG];

  logic [XLEN-1:0] laneMask;
  logic [2:0]      shAmt;
  logic [LOGX-1:0] off      [MAXSUB];
  logic [RIW-1:0]  dstIdx   [MAXSUB];
  logic [XLEN-1:0] sum      [MAXSUB];
  logic            laneAct  [MAXSUB];

  assign shAmt = {1'b0, cfg.elemW} + 3'd3;

  always_comb begin
    case (cfg.elemW)
      2'd0:    laneMask = XLEN'(64'h0000_0000_0000_00FF);
      2'd1:    laneMask = XLEN'(64'h0000_0000_0000_FFFF);
      2'd2:    laneMask = XLEN'(64'h0000_0000_FFFF_FFFF);
      default: laneMask = '1;
    endcase
  end

  for (genvar k = 0; k < MAXSUB; k++) begin : g_lane
    logic [IDXW-1:0] scIdx;
    logic [BPW-1:0]  bitPos;
    logic [RIW-1:0]  regOff;
    logic [RIW-1:0]  src1Idx;
    logic [RIW-1:0]  src2Idx;
    logic [XLEN-1:0] opA;
    logic [XLEN-1:0] opB;

    assign scIdx   = IDXW'(strb.groupIdx) * IDXW'(cfg.subLen) + IDXW'(k);
    assign bitPos  = BPW'(scIdx) << shAmt;
    assign regOff  = RIW'(bitPos >> LOGX);
    assign off[k]  = bitPos[LOGX-1:0];
    assign src1Idx = cfg.rs1Base + regOff;
    assign src2Idx = cfg.rs2Base + regOff;
    assign dstIdx[k] = cfg.rdBase + regOff;
    assign opA     = (regFile[src1Idx] >> off[k]) & laneMask;
    assign opB     = (regFile[src2Idx] >> off[k]) & laneMask;
    assign sum[k]  = (opA + opB) & laneMask;
    assign laneAct[k] = (SUBW'(k) < cfg.subLen);
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) nextRegs[r] = regFile[r];
    if (strb.hostWr) nextRegs[wrAddr] = wrData;
    if (strb.groupEn) begin
      for (int k = 0; k < MAXSUB; k++) begin
        if (laneAct[k]) begin
          nextRegs[dstIdx[k]] = (nextRegs[dstIdx[k]] & ~(laneMask << off[k]))
                              | (sum[k] << off[k]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) regFile[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) regFile[r] <= nextRegs[r];
    end
  end

  assign rdData = regFile[rdAddr];

  // R2: an accepted host write lands in the addressed register
  a_r2_host_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.hostWr |=> (regFile[$past(wrAddr)] == $past(wrData)));
  // R9: host writes are never accepted during a group step
  a_r9_no_host_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.doGroup |-> !strb.hostWr);
endmodule

// File: rtl/subvec_pred_adder.sv
module subvec_pred_adder
  import subvec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [4:0]       rdBase,
  input  logic [4:0]       rs1Base,
  input  logic [4:0]       rs2Base,
  input  logic [2:0]       subVecLen,
  input  logic [1:0]       elemWidth,
  input  logic [6:0]       vecLen,
  input  logic [63:0]      predMask,
  input  logic             predInvert,
  input  logic             wrEn,
  input  logic [4:0]       wrAddr,
  input  logic [63:0]      wrData,
  input  logic [4:0]       rdAddr,
  output logic             busy,
  output logic             done,
  output logic [63:0]      rdData
);
  opCfg_t    cfgIn;
  opCfg_t    cfgQ;
  dpStrobe_t strb;

  always_comb begin
    cfgIn.rdBase  = rdBase;
    cfgIn.rs1Base = rs1Base;
    cfgIn.rs2Base = rs2Base;
    cfgIn.subLen  = subVecLen;
    cfgIn.elemW   = elemWidth;
  end

  subvec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgIn(cfgIn),
    .vecLen(vecLen), .predMask(predMask), .predInvert(predInvert),
    .wrEn(wrEn), .cfgQ(cfgQ), .strb(strb), .busy(busy), .done(done)
  );

  subvec_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfgQ), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/subvec_pred_adder_bench.sv
`timescale 1ns/1ps
module subvec_pred_adder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  rdBase = '0, rs1Base = '0, rs2Base = '0;
  logic [2:0]  subVecLen = 3'd1;
  logic [1:0]  elemWidth = '0;
  logic [6:0]  vecLen = '0;
  logic [63:0] predMask = '0;
  logic        predInvert = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [4:0]  rdAddr = '0;
  logic        busy, done;
  logic [63:0] rdData;

  int checks = 0;
  int failures = 0;
  logic [63:0] refRegs [32];

  always #2 clk = ~clk;

  subvec_pred_adder u_subvec_pred_adder (
    .clk(clk), .rstN(rstN), .start(start), .rdBase(rdBase), .rs1Base(rs1Base),
    .rs2Base(rs2Base), .subVecLen(subVecLen), .elemWidth(elemWidth),
    .vecLen(vecLen), .predMask(predMask), .predInvert(predInvert),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .busy(busy), .done(done), .rdData(rdData)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] maskW(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] getS(int base, int j, int ew);
    int w = 8 << ew;
    int bp = j * w;
    return (refRegs[(base + bp / 64) % 32] >> (bp % 64)) & maskW(w);
  endfunction

  task automatic setS(int base, int j, int ew, logic [63:0] v);
    int w = 8 << ew;
    int bp = j * w;
    int r = (base + bp / 64) % 32;
    refRegs[r] = (refRegs[r] & ~(maskW(w) << (bp % 64))) | ((v & maskW(w)) << (bp % 64));
  endtask

  task automatic compareAll(string tag);
    for (int r = 0; r < 32; r++) begin
      rdAddr = 5'(r);
      #0.5;
      check(tag, rdData, refRegs[r]);
    end
  endtask

  task automatic hostWrite(int a, logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    refRegs[a] = d;
    rdAddr = 5'(a);
    #0.5;
    check("R2 host write readback", rdData, d);
  endtask

  task automatic runOp(int rd, int r1, int r2, int sub, int ew, int vl,
                       logic [63:0] pm, bit inv, bit injBusy, bit injSame,
                       int injAddr, logic [63:0] injData, string tag);
    logic [63:0] sums [4];
    @(negedge clk);
    start = 1'b1; rdBase = 5'(rd); rs1Base = 5'(r1); rs2Base = 5'(r2);
    subVecLen = 3'(sub); elemWidth = 2'(ew); vecLen = 7'(vl);
    predMask = pm; predInvert = inv;
    if (injSame) begin
      wrEn = 1'b1; wrAddr = 5'(injAddr); wrData = injData;
      refRegs[injAddr] = injData;
    end
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0;
    for (int c = 1; c <= vl + 1; c++) begin
      check({tag, " R7 busy per cycle"}, 64'(busy), 64'(c <= vl));
      check({tag, " R7/R8 done pulse"}, 64'(done), 64'(c == vl + 1));
      if (injBusy && c == 2) begin
        start = 1'b1; rdBase = 5'd0; vecLen = 7'd3; predMask = '1; predInvert = 1'b0;
        wrEn = 1'b1; wrAddr = 5'(injAddr); wrData = injData;
      end
      @(negedge clk);
      start = 1'b0; wrEn = 1'b0;
    end
    check({tag, " R7 done single cycle"}, 64'(done), 64'd0);
    for (int g = 0; g < vl; g++) begin
      if (pm[g] ^ inv) begin
        for (int k = 0; k < sub; k++)
          sums[k] = getS(r1, g * sub + k, ew) + getS(r2, g * sub + k, ew);
        for (int k = 0; k < sub; k++) setS(rd, g * sub + k, ew, sums[k]);
      end
    end
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++) refRegs[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset done", 64'(done), 64'd0);
    compareAll("R1 reset registers");

    for (int r = 0; r < 32; r++)
      hostWrite(r, 64'h9E37_79B9_7F4A_7C15 * 64'(r + 1) ^ 64'(r));

    // R3 R5 R6: three-scalar groups of 16 bits, five groups, inverted predicate
    runOp(8, 0, 4, 3, 1, 5, 64'h0000_0000_0000_0012, 1'b1, 0, 0, 0, '0, "R3 R5 R6 sub3 w16");

    // R4: 8-bit wraparound with neighbours in the same register
    hostWrite(16, 64'hFFFF_FFFF_FFFF_FFFF);
    hostWrite(17, 64'h0102_0304_0506_0708);
    hostWrite(18, 64'hF0F0_0F0F_8080_7F7F);
    runOp(20, 16, 17, 1, 0, 20, 64'h0000_0000_000F_FFFF, 1'b0, 0, 0, 0, '0, "R4 wrap w8");
    runOp(24, 18, 18, 1, 0, 8, 64'h0000_0000_0000_00FF, 1'b0, 0, 0, 0, '0, "R4 wrap self-add");

    // R3: four 64-bit scalars per group, destination index wraps past register 31
    runOp(28, 20, 10, 4, 3, 2, 64'h3, 1'b0, 0, 0, 0, '0, "R3 sub4 w64 reg wrap");

    // R3 R5: 32-bit pairs, alternating predicate
    runOp(2, 12, 22, 2, 2, 8, 64'h0000_0000_0000_00A5, 1'b0, 0, 0, 0, '0, "R3 R5 sub2 w32");

    // R8: empty vector
    runOp(0, 1, 2, 2, 1, 0, '1, 1'b0, 0, 0, 0, '0, "R8 empty vector");

    // R9: start and host write during an operation are dropped
    runOp(6, 10, 14, 2, 1, 6, '1, 1'b0, 1, 0, 30, 64'hDEAD_BEEF_0000_1111, "R9 ignore while busy");

    // R10: host write and start in the same cycle, write feeds group 0
    runOp(4, 9, 13, 4, 2, 3, '1, 1'b0, 0, 1, 9, 64'h7FFF_FFFF_0000_0001, "R10 same-cycle write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule